// File: doc/BRIEF.md
# Event Timer Register Block

This block holds the software-visible registers of an event timer with a parameterised number of comparator channels. It holds a read-only capability word, a global configuration word, a level-interrupt status word and a free-running 64-bit main counter. Each channel has a window with a configuration word, a comparator value and a message-route word. Every register is 64 bits wide. A 4-byte access reaches one dword half of a register and an 8-byte access reaches the whole register.

The main counter advances once per clock while the global enable bit is set. It holds its value while the bit is clear. Software may load the counter at any time. Comparator channels sit outside this block. They report expiries on `chan_event`, read their settings from the flat channel outputs, and use the `rearm` and `cancel` pulses to restart or drop their pending events when the global enable changes. Level-triggered channels latch status bits, which software clears by writing ones.

The bus uses dword addresses. Byte address A maps to `bus_dw_addr = A >> 2`, so dword address bit 0 is byte address bit 2. Global registers sit at byte offsets 0x000 (capability), 0x010 (configuration), 0x020 (status) and 0x0F0 (counter). Channel i starts at byte 0x100 + 0x20*i, with configuration at +0x00, comparator at +0x08 and route at +0x10.

Top module: `etr_regblock`

## Requirements
- R1: After reset the counter, global configuration and status are 0. Each channel's configuration reads with bit 4 (periodic-capable) and bit 5 (64-bit-capable) set and the route-capability mask in bits 63:32. Each comparator reads all ones and each route word reads 0.
- R2: The capability register at byte 0x000 is read-only. Bits 7:0 hold 0x01, bit 15 is 1, bits 12:8 hold NUM_CH-1, bits 63:32 hold the tick period in femtoseconds, and all other bits are 0.
- R3: On a 4-byte access, dword address bit 0 selects the upper (1) or lower (0) half of the register. Read data returns that half in bits 31:0 with bits 63:32 zero. An 8-byte access ignores that bit and reads or writes all 64 bits.
- R4: While global configuration bit 0 is 1, the counter increases by exactly one per clock. While that bit is 0, the counter holds its value.
- R5: A counter write (byte 0x0F0) is accepted whether the counter is running or not. In the cycle of the write, the written value replaces the increment. A 4-byte write changes only the selected half.
- R6: Only bits 0 (enable) and 1 (legacy route) of the global configuration are writable, and all its other bits read 0. In a channel configuration word only bits 1 (level type), 2 (interrupt enable), 3 (periodic), 8 (32-bit mode) and 13:9 (route) are writable, and the capability bits never change.
- R7: The status register is write-one-to-clear. A bit clears only where a 1 is written to a bit that is set. A `chan_event` pulse sets a channel's bit only when its level-type bit is 1. An event wins over a clear in the same cycle.
- R8: `chan_irq[i]` is high exactly when status bit i, channel i's interrupt-enable bit and the global enable bit are all 1.
- R9: `rearm` is a one-cycle pulse in the cycle after the global enable changes from 0 to 1. `cancel` is a one-cycle pulse in the cycle after it changes from 1 to 0.
- R10: Channel windows at or beyond NUM_CH read 0 and ignore writes. Byte offset +0x18 inside a window reads 0. Global offsets other than the four listed above read 0, and writes to them change nothing.
- R11: While a channel's 32-bit-mode bit (bit 8) is 1, its comparator's upper half is 0. Writes to the upper half are ignored, and a lower-half or 8-byte write loads only bits 31:0. Setting the bit clears the upper half of the comparator.
- R12: A read returns its data on `bus_rdata` with `bus_rvalid` high in the clock cycle after the request. A write never raises `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_wide | input | 1 | 1 for an 8-byte access, 0 for a 4-byte access |
| bus_dw_addr | input | 8 | Dword address (byte address bits 9:2) |
| bus_wdata | input | 64 | Write data; a 4-byte write uses bits 31:0 |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 64 | Read data |
| chan_event | input | NUM_CH | Per-channel expiry pulse from the comparators |
| count_o | output | 64 | Main counter value |
| timer_on | output | 1 | Global enable bit |
| legacy_route | output | 1 | Legacy route bit |
| rearm | output | 1 | Pulse after the enable rises |
| cancel | output | 1 | Pulse after the enable falls |
| chan_irq | output | NUM_CH | Per-channel level interrupt |
| chan_cfg_flat | output | NUM_CH*64 | Channel configuration words, channel i at bits 64i+63:64i |
| chan_cmp_flat | output | NUM_CH*64 | Channel comparator values |
| chan_msg_flat | output | NUM_CH*64 | Channel route words |

## Verification
The bench first targets the half-register paths. If the half select were inverted, or the high half were not shifted down on a read, the 4-byte reads of the capability word, the counter and the comparators would show the wrong dword. The status corners come next: writing ones to bits that are already clear, clearing through the upper half, and an event that arrives together with a clear. Wrong precedence in any of these either loses a pending interrupt or keeps a stale one. The bench then checks that a counter write while the counter is running lands exactly and is not followed by an extra increment. It also checks that 32-bit mode truncates the comparator and ignores upper writes, and that the window of a missing channel reads 0. A wrong range check would alias that window onto a real channel.

// File: rtl/etr_pkg.sv
package etr_pkg;
   localparam int REG_W = 64;
   localparam int DWA_W = 8;

   // dword address bits 5:1 select a global register (byte offset >> 3)
   localparam logic [4:0] G_CAP = 5'd0;
   localparam logic [4:0] G_CFG = 5'd2;
   localparam logic [4:0] G_STS = 5'd4;
   localparam logic [4:0] G_CNT = 5'd30;

   // channel configuration bit positions
   localparam int C_LVL  = 1;
   localparam int C_IEN  = 2;
   localparam int C_PER  = 3;
   localparam int C_PCAP = 4;
   localparam int C_SCAP = 5;
   localparam int C_M32  = 8;

   localparam logic [REG_W-1:0] CFG_WMASK  = 64'h0000_0000_0000_3F0E;
   localparam logic [REG_W-1:0] GCFG_WMASK = 64'h0000_0000_0000_0003;

   typedef enum logic [1:0] {W_CFG = 2'd0, W_CMP = 2'd1, W_MSG = 2'd2, W_NONE = 2'd3} win_reg_t;

   // place write data into the old value according to access size and half
   function automatic logic [REG_W-1:0] put_half(input logic [REG_W-1:0] old,
                                                 input logic [REG_W-1:0] wd,
                                                 input logic wide, input logic hi);
      if (wide)    return wd;
      else if (hi) return {wd[31:0], old[31:0]};
      else         return {old[63:32], wd[31:0]};
   endfunction
endpackage

// File: rtl/etr_decode.sv
module etr_decode import etr_pkg::*; #(
   parameter int NUM_CH = 3
) (
   input  logic [DWA_W-1:0] dw_addr,
   output logic             sel_cap,
   output logic             sel_cfg,
   output logic             sel_sts,
   output logic             sel_cnt,
   output logic             in_win,
   output logic             ch_hit,
   output logic [4:0]       ch_idx,
   output win_reg_t         ch_reg
);
   localparam logic [4:0] CH_LIM = 5'(NUM_CH);

   logic glob;

   always_comb begin
      glob    = (dw_addr[7:6] == 2'b00);
      sel_cap = glob && (dw_addr[5:1] == G_CAP);
      sel_cfg = glob && (dw_addr[5:1] == G_CFG);
      sel_sts = glob && (dw_addr[5:1] == G_STS);
      sel_cnt = glob && (dw_addr[5:1] == G_CNT);
      in_win  = !glob;
      ch_idx  = dw_addr[7:3] - 5'd8;
      ch_reg  = win_reg_t'(dw_addr[2:1]);
      ch_hit  = in_win && (ch_idx < CH_LIM) && (ch_reg != W_NONE);
   end
endmodule

// File: rtl/etr_counter.sv
module etr_counter import etr_pkg::*; (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             wr,
   input  logic             wide,
   input  logic             hi,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (wr)  cnt <= put_half(cnt, wdata, wide, hi);
      else if (run) cnt <= cnt + 1'b1;
   end

   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wr) |=> (cnt == $past(cnt) + 64'd1));
   a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr) |=> $stable(cnt));
endmodule

// File: rtl/etr_channel.sv
module etr_channel import etr_pkg::*; #(
   parameter logic [31:0] ROUTE_CAP = 32'h0000_0F00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cmp_we,
   input  logic             msg_we,
   input  logic             wide,
   input  logic             hi,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] cfg,
   output logic [REG_W-1:0] cmp,
   output logic [REG_W-1:0] msg
);
   localparam logic [REG_W-1:0] CFG_RST = {ROUTE_CAP, 32'h0} | (64'd1 << C_PCAP) | (64'd1 << C_SCAP);

   logic [REG_W-1:0] cfg_new;
   assign cfg_new = (put_half(cfg, wdata, wide, hi) & CFG_WMASK) | (cfg & ~CFG_WMASK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg <= CFG_RST;
         cmp <= '1;
         msg <= '0;
      end else begin
         if (cfg_we) begin
            cfg <= cfg_new;
            if (cfg_new[C_M32]) cmp <= {32'h0, cmp[31:0]};
         end
         if (cmp_we) begin
            if (!cfg[C_M32])        cmp <= put_half(cmp, wdata, wide, hi);
            else if (wide || !hi)   cmp <= {32'h0, wdata[31:0]};
         end
         if (msg_we) msg <= put_half(msg, wdata, wide, hi);
      end
   end

   a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[C_M32] |-> (cmp[63:32] == 32'h0));
endmodule

// File: rtl/etr_regblock.sv
module etr_regblock import etr_pkg::*; #(
   parameter int          NUM_CH    = 3,
   parameter int unsigned TICK_FS   = 10_000_000,
   parameter logic [31:0] ROUTE_CAP = 32'h0000_0F00
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_valid,
   input  logic                    bus_write,
   input  logic                    bus_wide,
   input  logic [7:0]              bus_dw_addr,
   input  logic [63:0]             bus_wdata,
   output logic                    bus_rvalid,
   output logic [63:0]             bus_rdata,
   input  logic [NUM_CH-1:0]       chan_event,
   output logic [63:0]             count_o,
   output logic                    timer_on,
   output logic                    legacy_route,
   output logic                    rearm,
   output logic                    cancel,
   output logic [NUM_CH-1:0]       chan_irq,
   output logic [NUM_CH*64-1:0]    chan_cfg_flat,
   output logic [NUM_CH*64-1:0]    chan_cmp_flat,
   output logic [NUM_CH*64-1:0]    chan_msg_flat
);
   localparam logic [REG_W-1:0] CAP_WORD =
      {32'(TICK_FS), 16'h0, 1'b1, 2'b00, 5'(NUM_CH - 1), 8'h01};
   localparam logic [REG_W-1:0] STS_MASK = (64'd1 << NUM_CH) - 64'd1;

   if (NUM_CH < 3 || NUM_CH > 24) begin : g_bad_ch
      $error("etr_regblock: NUM_CH must lie in 3..24 to fit the channel windows");
   end

   logic     sel_cap, sel_cfg, sel_sts, sel_cnt, in_win, ch_hit;
   logic [4:0] ch_idx;
   win_reg_t ch_reg;
   logic     wr, rd, hi;

   assign wr = bus_valid && bus_write;
   assign rd = bus_valid && !bus_write;
   assign hi = bus_dw_addr[0];

   etr_decode #(.NUM_CH(NUM_CH)) u_dec (
      .dw_addr(bus_dw_addr), .sel_cap(sel_cap), .sel_cfg(sel_cfg), .sel_sts(sel_sts),
      .sel_cnt(sel_cnt), .in_win(in_win), .ch_hit(ch_hit), .ch_idx(ch_idx), .ch_reg(ch_reg));

   // global configuration and enable edges
   logic [REG_W-1:0] gcfg_q;
   logic             en_d;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gcfg_q <= '0;
         en_d   <= 1'b0;
      end else begin
         en_d <= gcfg_q[0];
         if (wr && sel_cfg) gcfg_q <= put_half(gcfg_q, bus_wdata, bus_wide, hi) & GCFG_WMASK;
      end
   end
   assign timer_on     = gcfg_q[0];
   assign legacy_route = gcfg_q[1];
   assign rearm        = gcfg_q[0] && !en_d;
   assign cancel       = !gcfg_q[0] && en_d;

   etr_counter u_cnt (
      .clk(clk), .rst_n(rst_n), .run(gcfg_q[0]), .wr(wr && sel_cnt),
      .wide(bus_wide), .hi(hi), .wdata(bus_wdata), .cnt(count_o));

   // channels
   logic [REG_W-1:0] cfg_a [NUM_CH];
   logic [REG_W-1:0] cmp_a [NUM_CH];
   logic [REG_W-1:0] msg_a [NUM_CH];
   logic [NUM_CH-1:0] lvl_v, ien_v;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic mine;
      assign mine = wr && ch_hit && (ch_idx == 5'(i));
      etr_channel #(.ROUTE_CAP(ROUTE_CAP)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .cfg_we(mine && ch_reg == W_CFG), .cmp_we(mine && ch_reg == W_CMP),
         .msg_we(mine && ch_reg == W_MSG), .wide(bus_wide), .hi(hi), .wdata(bus_wdata),
         .cfg(cfg_a[i]), .cmp(cmp_a[i]), .msg(msg_a[i]));
      assign chan_cfg_flat[i*64 +: 64] = cfg_a[i];
      assign chan_cmp_flat[i*64 +: 64] = cmp_a[i];
      assign chan_msg_flat[i*64 +: 64] = msg_a[i];
      assign lvl_v[i] = cfg_a[i][C_LVL];
      assign ien_v[i] = cfg_a[i][C_IEN];
   end

   // level status, write-one-to-clear, event has priority
   logic [REG_W-1:0] sts_q, clr64, set64;
   assign clr64 = (wr && sel_sts) ? put_half('0, bus_wdata, bus_wide, hi) : '0;
   assign set64 = {{(REG_W-NUM_CH){1'b0}}, chan_event & lvl_v};
   always_ff @(posedge clk) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= ((sts_q & ~clr64) | set64) & STS_MASK;
   end
   assign chan_irq = sts_q[NUM_CH-1:0] & ien_v & {NUM_CH{gcfg_q[0]}};

   // read path
   logic [REG_W-1:0] rd64;
   always_comb begin
      rd64 = '0;
      if (sel_cap)      rd64 = CAP_WORD;
      else if (sel_cfg) rd64 = gcfg_q;
      else if (sel_sts) rd64 = sts_q;
      else if (sel_cnt) rd64 = count_o;
      else if (ch_hit) begin
         for (int k = 0; k < NUM_CH; k++) begin
            if (ch_idx == 5'(k)) begin
               case (ch_reg)
                  W_CFG:   rd64 = cfg_a[k];
                  W_CMP:   rd64 = cmp_a[k];
                  W_MSG:   rd64 = msg_a[k];
                  default: rd64 = '0;
               endcase
            end
         end
      end
   end

   logic oor_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
         oor_q      <= 1'b0;
      end else begin
         bus_rvalid <= rd;
         oor_q      <= rd && in_win && !ch_hit;
         if (rd) bus_rdata <= bus_wide ? rd64 : {32'h0, (hi ? rd64[63:32] : rd64[31:0])};
      end
   end

   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr64 & ~set64) != '0) |=> ((sts_q & $past(clr64 & ~set64)) == '0));
   a_r9_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      rearm |-> (timer_on && !$past(timer_on)));
   a_r9_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      cancel |-> (!timer_on && $past(timer_on)));
   a_r10_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
      oor_q |-> (bus_rdata == '0));
   a_r12_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_valid && !bus_write));
endmodule

// File: tb/sim_etr_regblock.sv
module sim_etr_regblock;
   localparam int CLK_NS = 10;
   localparam int NCH = 3;
   localparam logic [63:0] WMASK = 64'h3F0E;

   logic clk = 0, rst_n = 0;
   logic bus_valid = 0, bus_write = 0, bus_wide = 0;
   logic [7:0] bus_dw_addr = 0;
   logic [63:0] bus_wdata = 0;
   logic bus_rvalid;
   logic [63:0] bus_rdata;
   logic [NCH-1:0] chan_event = 0;
   logic [63:0] count_o;
   logic timer_on, legacy_route, rearm, cancel;
   logic [NCH-1:0] chan_irq;
   logic [NCH*64-1:0] cfgf, cmpf, msgf;

   etr_regblock u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_wide(bus_wide), .bus_dw_addr(bus_dw_addr), .bus_wdata(bus_wdata),
      .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .chan_event(chan_event),
      .count_o(count_o), .timer_on(timer_on), .legacy_route(legacy_route),
      .rearm(rearm), .cancel(cancel), .chan_irq(chan_irq),
      .chan_cfg_flat(cfgf), .chan_cmp_flat(cmpf), .chan_msg_flat(msgf));

   always #(CLK_NS/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [63:0] m_cfg [NCH];
   logic [63:0] m_cmp [NCH];
   logic [63:0] m_msg [NCH];
   logic [63:0] rv, c0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] ins(input logic [63:0] o, input logic [63:0] d,
                                       input bit w, input bit h);
      if (w) return d;
      return h ? {d[31:0], o[31:0]} : {o[63:32], d[31:0]};
   endfunction

   function automatic logic [63:0] view(input logic [63:0] v, input bit w, input bit h);
      if (w) return v;
      return {32'h0, h ? v[63:32] : v[31:0]};
   endfunction

   task automatic wr(input logic [9:0] ba, input logic [63:0] d, input bit w);
      bus_valid = 1; bus_write = 1; bus_wide = w; bus_dw_addr = ba[9:2]; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_valid = 0; bus_write = 0;
   endtask

   task automatic rd(input logic [9:0] ba, input bit w, output logic [63:0] d);
      bus_valid = 1; bus_write = 0; bus_wide = w; bus_dw_addr = ba[9:2];
      @(posedge clk); @(negedge clk);
      bus_valid = 0;
      d = bus_rdata;
      chk("R12 rvalid after read", {63'h0, bus_rvalid}, 64'd1);
   endtask

   function automatic logic [9:0] cha(input int ch, input int rg, input bit h);
      return 10'(32'h100 + ch*32 + rg*8 + (h ? 4 : 0));
   endfunction

   // write a channel register and update the model from the requirements (R6, R11)
   task automatic chwr(input int ch, input int rg, input logic [63:0] d, input bit w, input bit h);
      logic [63:0] n;
      wr(cha(ch, rg, h), d, w);
      if (rg == 0) begin
         n = (ins(m_cfg[ch], d, w, h) & WMASK) | (m_cfg[ch] & ~WMASK);
         m_cfg[ch] = n;
         if (n[8]) m_cmp[ch][63:32] = 32'h0;
      end else if (rg == 1) begin
         if (!m_cfg[ch][8]) m_cmp[ch] = ins(m_cmp[ch], d, w, h);
         else if (w || !h)  m_cmp[ch] = {32'h0, d[31:0]};
      end else if (rg == 2) m_msg[ch] = ins(m_msg[ch], d, w, h);
   endtask

   function automatic logic [63:0] mval(input int ch, input int rg);
      if (rg == 0) return m_cfg[ch];
      if (rg == 1) return m_cmp[ch];
      return m_msg[ch];
   endfunction

   initial begin
      #(CLK_NS * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] capw;
      int s;
      s = $urandom(32'd2024);
      capw = {32'd10000000, 16'h0, 1'b1, 2'b00, 5'd2, 8'h01};
      for (int i = 0; i < NCH; i++) begin
         m_cfg[i] = 64'h0000_0F00_0000_0030; m_cmp[i] = '1; m_msg[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk("R1 counter", count_o, 0);
      chk("R1 enable", {63'h0, timer_on}, 0);
      chk("R1 rvalid", {63'h0, bus_rvalid}, 0);
      for (int i = 0; i < NCH; i++) begin
         rd(cha(i, 0, 0), 1, rv); chk("R1 channel cfg", rv, m_cfg[i]);
         rd(cha(i, 1, 0), 1, rv); chk("R1 channel cmp", rv, 64'hFFFF_FFFF_FFFF_FFFF);
      end
      rd(10'h020, 1, rv); chk("R1 status", rv, 0);
      rd(10'h010, 1, rv); chk("R1 gcfg", rv, 0);

      // R2 / R3 capability and halves
      rd(10'h000, 1, rv); chk("R2 cap wide", rv, capw);
      rd(10'h004, 1, rv); chk("R3 wide ignores half bit", rv, capw);
      rd(10'h004, 0, rv); chk("R3 cap upper half", rv, {32'h0, capw[63:32]});
      rd(10'h000, 0, rv); chk("R3 cap lower half", rv, {32'h0, capw[31:0]});
      wr(10'h000, 64'h1234_5678_9ABC_DEF0, 1);
      chk("R12 no rvalid on write", {63'h0, bus_rvalid}, 0);
      rd(10'h000, 1, rv); chk("R2 cap read-only", rv, capw);

      // R4 / R5 counter while stopped
      repeat (5) @(negedge clk);
      chk("R4 hold while disabled", count_o, 0);
      wr(10'h0F4, 64'hAABB_CCDD, 0);
      chk("R5 upper half write", count_o, 64'hAABB_CCDD_0000_0000);
      rd(10'h0F4, 0, rv); chk("R3 counter upper read", rv, 64'hAABB_CCDD);
      rd(10'h0F0, 0, rv); chk("R3 counter lower read", rv, 0);
      wr(10'h0F0, 64'h10, 1);
      chk("R5 wide write", count_o, 64'h10);

      // R6 / R9 enable
      wr(10'h010, 64'hFFFF_FFFF_FFFF_FFFF, 1);
      chk("R9 rearm pulse", {63'h0, rearm}, 1);
      chk("R4 first cycle", count_o, 64'h10);
      chk("R6 legacy bit", {63'h0, legacy_route}, 1);
      @(negedge clk);
      chk("R9 rearm single cycle", {63'h0, rearm}, 0);
      c0 = count_o;
      repeat (6) @(negedge clk);
      chk("R4 step per clock", count_o, c0 + 6);
      rd(10'h010, 1, rv); chk("R6 gcfg mask", rv, 64'h3);
      wr(10'h0F0, 64'h500, 1);
      chk("R5 write wins while running", count_o, 64'h500);
      @(negedge clk);
      chk("R5 resumes counting", count_o, 64'h501);
      wr(10'h010, 64'h1, 0);
      chk("R6 legacy cleared", {63'h0, legacy_route}, 0);

      // R7 / R8 status
      chwr(0, 0, 64'h6, 1, 0);
      chwr(1, 0, 64'h4, 1, 0);
      chan_event = 3'b011; @(negedge clk); chan_event = 0;
      rd(10'h020, 1, rv); chk("R7 level event sets only level channel", rv, 64'h1);
      chk("R8 irq", {61'h0, chan_irq}, 64'h1);
      wr(10'h020, 64'h6, 1);
      rd(10'h020, 1, rv); chk("R7 ones on clear bits no effect", rv, 64'h1);
      wr(10'h024, 64'h1, 0);
      rd(10'h020, 1, rv); chk("R7 upper half clear no effect", rv, 64'h1);
      wr(10'h020, 64'h1, 0);
      rd(10'h020, 1, rv); chk("R7 clear", rv, 0);
      chk("R8 irq drops", {61'h0, chan_irq}, 0);
      chan_event = 3'b001;
      wr(10'h020, 64'h1, 1);
      chan_event = 0;
      rd(10'h020, 1, rv); chk("R7 event beats clear", rv, 64'h1);
      wr(10'h010, 64'h0, 1);
      chk("R9 cancel pulse", {63'h0, cancel}, 1);
      chk("R8 irq gated by enable", {61'h0, chan_irq}, 0);
      @(negedge clk);
      chk("R9 cancel single cycle", {63'h0, cancel}, 0);
      c0 = count_o;
      repeat (4) @(negedge clk);
      chk("R4 halted", count_o, c0);
      rd(10'h0F0, 1, rv); chk("R5 counter read matches", rv, c0);

      // R10 out of range and holes
      wr(10'h160, 64'hFFFF_FFFF_FFFF_FFFF, 1);
      rd(10'h160, 1, rv); chk("R10 absent channel", rv, 0);
      rd(10'h118, 1, rv); chk("R10 window hole", rv, 0);
      rd(10'h008, 1, rv); chk("R10 undefined global", rv, 0);
      wr(10'h0F8, 64'h77, 1);
      rd(10'h0F8, 1, rv); chk("R10 undefined global write", rv, 0);
      for (int i = 0; i < NCH; i++) begin
         rd(cha(i, 0, 0), 1, rv); chk("R10 real channels untouched", rv, m_cfg[i]);
      end

      // R11 32-bit mode
      chwr(2, 1, 64'h1122_3344_5566_7788, 1, 0);
      chwr(2, 0, 64'h100, 1, 0);
      rd(cha(2, 1, 0), 1, rv); chk("R11 truncate on mode set", rv, 64'h5566_7788);
      chwr(2, 1, 64'hDEAD, 0, 1);
      rd(cha(2, 1, 0), 1, rv); chk("R11 upper write ignored", rv, 64'h5566_7788);
      chwr(2, 1, 64'hFFFF_FFFF_0000_0042, 1, 0);
      rd(cha(2, 1, 0), 1, rv); chk("R11 wide write loads low only", rv, 64'h42);

      // random channel traffic against the model (R3 R6 R11)
      for (int n = 0; n < 80; n++) begin
         int ch, rg;
         bit w, h;
         ch = int'($urandom % NCH); rg = int'($urandom % 3);
         w = 1'($urandom); h = 1'($urandom);
         chwr(ch, rg, {$urandom, $urandom}, w, h);
         ch = int'($urandom % NCH); rg = int'($urandom % 3);
         w = 1'($urandom); h = 1'($urandom);
         rd(cha(ch, rg, h), w, rv);
         chk("R6 R11 R3 random readback", rv, view(mval(ch, rg), w, h));
      end
      for (int i = 0; i < NCH; i++) begin
         chk("R6 cfg port", cfgf[i*64 +: 64], m_cfg[i]);
         chk("R11 cmp port", cmpf[i*64 +: 64], m_cmp[i]);
         chk("R3 msg port", msgf[i*64 +: 64], m_msg[i]);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule